// File: doc/BRIEF.md
# Probe Mode Halt Controller

This block sits between an external debug tool, the system board and a small processor core. When run/scan goes low, the block raises a freeze request. The core stops at its next instruction boundary, which the block sees as a one-cycle pulse. Only then does the block raise probe-ready. When run/scan goes high again, both freeze and probe-ready fall and the core resumes.

A strap tells the block whether a debug tool is fitted. With the strap high, the board's run/scan request is used. With the strap low, the board request is blocked and the tool's request is used. The board request stays visible on a monitor output in both cases. A separate active-low select routes either the tool's or the board's four test-port signals to the core's TAP.

The block also holds four debug registers of width W on a single access port:

| Address | Register |
|---|---|
| 0 | data register A |
| 1 | data register B |
| 2 | status |
| 3 | control |

The control register's top bit (bit W-1) is a guard bit. While it is set, any program access is refused and sets the detect flag, which is the top bit (bit W-1) of the status register. Tool accesses work only while probe-ready is high.

Top module: `probe_halt_ctrl`

## Requirements
- R1: When the effective run/scan is low, `freeze_req` is high. `prdy` rises only on the clock edge that samples an `insn_boundary` pulse while a freeze is pending. A boundary pulse while running does not halt the core.
- R2: A pending freeze with no boundary pulse keeps `freeze_req` high and `prdy` low indefinitely. `prdy` is never high without `freeze_req`.
- R3: After the effective run/scan returns high, `prdy` and `freeze_req` stay high for two more edges and are low after the third rising edge.
- R4: With `dbg_present_n` = 1, the effective run/scan is `board_rs_n`. With `dbg_present_n` = 0, it is `tool_rs_n`.
- R5: With `scan_sel_n` = 0, `core_tdi/tms/tck/trst_n` equal the tool's signals. With `scan_sel_n` = 1, they equal the board's signals. This path is combinational.
- R6: `board_rs_mon` always equals `board_rs_n`, whichever source is in control.
- R7: A program access (`dbg_acc_tool` = 0) while control bit W-1 is 1 sets status bit W-1 on the next edge and returns zero on `dbg_rdata`.
- R8: A refused program access leaves both data registers and the control register unchanged. A program access while the guard bit is 0 reads and writes normally.
- R9: A tool access (`dbg_acc_tool` = 1) takes effect only while `prdy` is high. Outside probe mode it reads zero and writes nothing. In probe mode the tool can read the status register, including the detect flag, and can write any register.
- R10: Reset leaves the block in the run state with `freeze_req` and `prdy` low and all debug registers zero.
- R11: The strap and both run/scan inputs pass through two synchroniser flops. A change on an input shows on `freeze_req` after the third rising edge, not the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tool_rs_n | input | 1 | Tool run/scan, low requests halt |
| board_rs_n | input | 1 | Board run/scan, low requests halt |
| dbg_present_n | input | 1 | Strap, low when a debug tool is fitted |
| scan_sel_n | input | 1 | Low routes the tool's test-port signals to the core |
| tool_tdi | input | 1 | Tool serial data |
| tool_tms | input | 1 | Tool mode select |
| tool_tck | input | 1 | Tool test clock |
| tool_trst_n | input | 1 | Tool test reset |
| board_tdi | input | 1 | Board serial data |
| board_tms | input | 1 | Board mode select |
| board_tck | input | 1 | Board test clock |
| board_trst_n | input | 1 | Board test reset |
| core_tdi | output | 1 | Serial data to core TAP |
| core_tms | output | 1 | Mode select to core TAP |
| core_tck | output | 1 | Test clock to core TAP |
| core_trst_n | output | 1 | Test reset to core TAP |
| board_rs_mon | output | 1 | Monitor copy of board run/scan |
| insn_boundary | input | 1 | One-cycle pulse at each core instruction boundary |
| freeze_req | output | 1 | Freeze request to core |
| prdy | output | 1 | Core halted, probe mode active |
| dbg_acc | input | 1 | Debug register access strobe |
| dbg_acc_tool | input | 1 | 1 for a tool access, 0 for a program access |
| dbg_wr | input | 1 | 1 write, 0 read |
| dbg_addr | input | 2 | Register select, as in the address table above |
| dbg_wdata | input | W | Write data |
| dbg_rdata | output | W | Read data, zero when the access is not granted |

## Verification
A wrong halt state shows first on `prdy`. It would rise without a boundary pulse, stay low after one, or linger past the third edge after release. Each of these is visible within one cycle of the expected edge. A wrong source or synchroniser depth moves the `freeze_req` edge by a cycle or inverts it, so the bench samples the exact edge. A wrong guard decision only appears on a later tool read in probe mode, as a changed register or a missing detect flag. The bench therefore reads every register back after each refused access.

// File: rtl/probe_halt_ctrl.sv
module probe_halt_ctrl #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tool_rs_n,
  input  logic         board_rs_n,
  input  logic         dbg_present_n,
  input  logic         scan_sel_n,
  input  logic         tool_tdi,
  input  logic         tool_tms,
  input  logic         tool_tck,
  input  logic         tool_trst_n,
  input  logic         board_tdi,
  input  logic         board_tms,
  input  logic         board_tck,
  input  logic         board_trst_n,
  output logic         core_tdi,
  output logic         core_tms,
  output logic         core_tck,
  output logic         core_trst_n,
  output logic         board_rs_mon,
  input  logic         insn_boundary,
  output logic         freeze_req,
  output logic         prdy,
  input  logic         dbg_acc,
  input  logic         dbg_acc_tool,
  input  logic         dbg_wr,
  input  logic [1:0]   dbg_addr,
  input  logic [W-1:0] dbg_wdata,
  output logic [W-1:0] dbg_rdata
);
  localparam int GUARD = W - 1;

  typedef enum logic [1:0] {RUN, PEND, HALT} st_t;
  st_t st;

  logic [2:0] s1, s2;
  logic rs_eff, gd, grant, blocked;
  logic [W-1:0] dra, drb, stat, ctrl;

  assign core_tdi     = scan_sel_n ? board_tdi    : tool_tdi;
  assign core_tms     = scan_sel_n ? board_tms    : tool_tms;
  assign core_tck     = scan_sel_n ? board_tck    : tool_tck;
  assign core_trst_n  = scan_sel_n ? board_trst_n : tool_trst_n;
  assign board_rs_mon = board_rs_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 3'b111;
      s2 <= 3'b111;
    end else begin
      s1 <= {dbg_present_n, board_rs_n, tool_rs_n};
      s2 <= s1;
    end

  assign rs_eff = s2[2] ? s2[1] : s2[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= RUN;
    else case (st)
      RUN:     if (!rs_eff) st <= PEND;
      PEND:    if (rs_eff) st <= RUN;
               else if (insn_boundary) st <= HALT;
      default: if (rs_eff) st <= RUN;
    endcase

  assign freeze_req = (st != RUN);
  assign prdy       = (st == HALT);

  assign gd      = ctrl[GUARD];
  assign blocked = dbg_acc && !dbg_acc_tool && gd;
  assign grant   = dbg_acc && (dbg_acc_tool ? prdy : !gd);

  always_comb begin
    dbg_rdata = '0;
    if (grant && !dbg_wr)
      case (dbg_addr)
        2'd0:    dbg_rdata = dra;
        2'd1:    dbg_rdata = drb;
        2'd2:    dbg_rdata = stat;
        default: dbg_rdata = ctrl;
      endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dra  <= '0;
      drb  <= '0;
      stat <= '0;
      ctrl <= '0;
    end else if (blocked) begin
      stat[GUARD] <= 1'b1;
    end else if (grant && dbg_wr) begin
      case (dbg_addr)
        2'd0:    dra  <= dbg_wdata;
        2'd1:    drb  <= dbg_wdata;
        2'd2:    stat <= dbg_wdata;
        default: ctrl <= dbg_wdata;
      endcase
    end
endmodule

// File: rtl/probe_halt_chk.sv
module probe_halt_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         freeze_req,
  input logic         prdy,
  input logic         insn_boundary,
  input logic         dbg_acc,
  input logic         dbg_acc_tool,
  input logic         gd,
  input logic [W-1:0] dra,
  input logic [W-1:0] drb,
  input logic [W-1:0] stat,
  input logic [W-1:0] ctrl
);
  p_prdy_needs_freeze_r2: assert property (@(posedge clk) disable iff (!rst_n)
    prdy |-> freeze_req);

  p_halt_on_boundary_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prdy) |-> ($past(insn_boundary) && $past(freeze_req)));

  p_refused_keeps_regs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_acc && !dbg_acc_tool && gd) |=> ($stable(dra) && $stable(drb) && $stable(ctrl)));

  p_refused_sets_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_acc && !dbg_acc_tool && gd) |=> stat[W-1]);

  p_tool_outside_probe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_acc && dbg_acc_tool && !prdy) |=>
      ($stable(dra) && $stable(drb) && $stable(stat) && $stable(ctrl)));
endmodule

bind probe_halt_ctrl probe_halt_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .freeze_req(freeze_req), .prdy(prdy),
  .insn_boundary(insn_boundary), .dbg_acc(dbg_acc), .dbg_acc_tool(dbg_acc_tool),
  .gd(gd), .dra(dra), .drb(drb), .stat(stat), .ctrl(ctrl)
);

// File: tb/tb_probe_halt_ctrl.sv
`timescale 1ns/1ps
module tb_probe_halt_ctrl;
  localparam int W = 16;
  localparam logic [W-1:0] FLAG = 16'h8000;

  logic clk = 0, rst_n;
  logic tool_rs_n, board_rs_n, dbg_present_n, scan_sel_n;
  logic [3:0] tool_t, board_t;
  logic core_tdi, core_tms, core_tck, core_trst_n, board_rs_mon;
  logic insn_boundary, freeze_req, prdy;
  logic dbg_acc, dbg_acc_tool, dbg_wr;
  logic [1:0] dbg_addr;
  logic [W-1:0] dbg_wdata, dbg_rdata, rd;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  probe_halt_ctrl #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .tool_rs_n(tool_rs_n), .board_rs_n(board_rs_n),
    .dbg_present_n(dbg_present_n), .scan_sel_n(scan_sel_n),
    .tool_tdi(tool_t[3]), .tool_tms(tool_t[2]), .tool_tck(tool_t[1]), .tool_trst_n(tool_t[0]),
    .board_tdi(board_t[3]), .board_tms(board_t[2]), .board_tck(board_t[1]), .board_trst_n(board_t[0]),
    .core_tdi(core_tdi), .core_tms(core_tms), .core_tck(core_tck), .core_trst_n(core_trst_n),
    .board_rs_mon(board_rs_mon), .insn_boundary(insn_boundary),
    .freeze_req(freeze_req), .prdy(prdy), .dbg_acc(dbg_acc), .dbg_acc_tool(dbg_acc_tool),
    .dbg_wr(dbg_wr), .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic acc(input logic tool, input logic wr, input logic [1:0] a,
                     input logic [W-1:0] d, output logic [W-1:0] r);
    dbg_acc = 1; dbg_acc_tool = tool; dbg_wr = wr; dbg_addr = a; dbg_wdata = d;
    #1 r = dbg_rdata;
    @(posedge clk); @(negedge clk);
    dbg_acc = 0; dbg_wr = 0;
  endtask

  task automatic halt_core();
    tool_rs_n = 0;
    edges(4);
    insn_boundary = 1;
    edges(1);
    insn_boundary = 0;
    check("R1 prdy after boundary", prdy, 1);
  endtask

  task automatic release_core();
    tool_rs_n = 1;
    edges(4);
    check("R3 released", {freeze_req, prdy}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; tool_rs_n = 1; board_rs_n = 1; dbg_present_n = 1; scan_sel_n = 1;
    tool_t = 0; board_t = 0; insn_boundary = 0;
    dbg_acc = 0; dbg_acc_tool = 0; dbg_wr = 0; dbg_addr = 0; dbg_wdata = 0;
    edges(3);
    rst_n = 1;
    edges(1);
    check("R10 reset outputs", {freeze_req, prdy}, 0);
    for (int a = 0; a < 4; a++) begin
      acc(0, 0, a[1:0], 0, rd);
      check("R10 reset regs zero", rd, 0);
    end

    for (int i = 0; i < 32; i++) begin
      scan_sel_n = i[4]; tool_t = i[3:0]; board_t = ~i[3:0];
      #1;
      check("R5 scan mux", {core_tdi, core_tms, core_tck, core_trst_n},
            i[4] ? {28'd0, ~i[3:0]} : {28'd0, i[3:0]});
    end

    for (int i = 0; i < 8; i++) begin
      dbg_present_n = i[2]; board_rs_n = i[1]; tool_rs_n = i[0];
      edges(4);
      check("R4 source select", freeze_req, i[2] ? !i[1] : !i[0]);
      check("R6 board monitor", board_rs_mon, i[1]);
      check("R2 no boundary no prdy", prdy, 0);
    end

    dbg_present_n = 0; board_rs_n = 1; tool_rs_n = 1;
    edges(4);
    insn_boundary = 1; edges(1); insn_boundary = 0;
    check("R1 boundary while running", {freeze_req, prdy}, 0);
    board_rs_n = 0;
    edges(4);
    check("R4 board blocked by strap", freeze_req, 0);
    check("R6 board monitor low", board_rs_mon, 0);
    board_rs_n = 1;

    tool_rs_n = 0;
    edges(2);
    check("R11 not after two edges", freeze_req, 0);
    edges(1);
    check("R11 after three edges", freeze_req, 1);
    edges(10);
    check("R2 pending holds", {freeze_req, prdy}, 2'b10);
    insn_boundary = 1; edges(1); insn_boundary = 0;
    check("R1 halted at boundary", {freeze_req, prdy}, 2'b11);
    insn_boundary = 1; edges(3); insn_boundary = 0;
    check("R2 halt survives boundaries", prdy, 1);
    tool_rs_n = 1;
    edges(2);
    check("R3 held two edges", prdy, 1);
    edges(1);
    check("R3 dropped third edge", {freeze_req, prdy}, 0);

    acc(0, 1, 0, 16'h1234, rd);
    acc(0, 0, 0, 0, rd);
    check("R8 program access unguarded", rd, 16'h1234);
    acc(1, 1, 1, 16'h5555, rd);
    acc(1, 0, 1, 0, rd);
    check("R9 tool read outside probe", rd, 0);

    halt_core();
    acc(1, 0, 1, 0, rd);
    check("R9 tool write outside probe ignored", rd, 0);
    acc(1, 1, 3, FLAG, rd);
    acc(1, 0, 2, 0, rd);
    check("R9 status clear before detect", rd, 0);
    release_core();

    for (int a = 0; a < 4; a++) begin
      acc(0, 1, a[1:0], 16'hBEEF, rd);
      acc(0, 0, a[1:0], 0, rd);
      check("R7 refused read zero", rd, 0);
    end

    halt_core();
    acc(1, 0, 0, 0, rd);
    check("R8 reg A unchanged", rd, 16'h1234);
    acc(1, 0, 1, 0, rd);
    check("R8 reg B unchanged", rd, 0);
    acc(1, 0, 3, 0, rd);
    check("R8 control unchanged", rd, FLAG);
    acc(1, 0, 2, 0, rd);
    check("R7 detect flag readable", rd, FLAG);
    acc(1, 1, 2, 0, rd);
    acc(1, 0, 2, 0, rd);
    check("R9 tool clears status", rd, 0);
    acc(1, 1, 3, 0, rd);
    release_core();

    acc(0, 1, 1, 16'h0F0F, rd);
    acc(0, 0, 1, 0, rd);
    check("R8 guard cleared access works", rd, 16'h0F0F);
    acc(0, 0, 2, 0, rd);
    check("R7 no flag when unguarded", rd, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule